// File: doc/BRIEF.md
# Data-strobe serial encoder

This block turns a stream of parallel words (bytes by default) into two serial wires, a data line and a strobe line, for a camera-style link that sends no clock wire. Words enter through a valid/ready handshake. A one-cycle bit-period pulse from the system clock domain sets the bit rate. Each pulse puts the next bit on the data line, least significant bit first. At every bit boundary exactly one of the two wires changes. The data wire changes when the new bit differs from the previous one. The strobe wire changes when the new bit repeats the previous one. A receiver can therefore rebuild the bit clock from the XOR of the two lines, and each wire changes at most once per bit.

A second word can be accepted while the last bit of the current word is on the line. Consecutive words then leave without a gap. When no word is waiting at the end of a word, the data line returns to its high idle level and the strobe keeps its value. The first bit after idle is coded against an assumed previous bit of 1.

Top module: `ds_strobe_encoder`

## Requirements
- R1: In the cycle after synchronous reset is released, `ds_data` is 1, `ds_strobe` is 0 and `in_ready` is 1.
- R2: Each emitted bit appears on `ds_data` in the cycle after the `bit_tick` that emits it. Bit i of a word (bit 0 first) is the i-th bit sent.
- R3: Consider each emitted bit. If it equals the previous `ds_data` value, `ds_strobe` inverts and `ds_data` holds. Otherwise `ds_data` takes the new value and `ds_strobe` holds. Exactly one of the two lines changes.
- R4: In a cycle without `bit_tick`, `ds_data` and `ds_strobe` keep their values.
- R5: If a tick arrives when the last bit of a word is on the line and no word is available, the encoder goes idle. In idle, `ds_data` is 1 and `ds_strobe` keeps its value. The first bit after idle is coded by R3 against a previous bit of 1.
- R6: `in_ready` is 1 only when no accepted word is waiting and the encoder is either idle or has bit WORD_W-1 of its current word on the line. It is 0 in the cycle after any accepted transfer.
- R7: Suppose a word is presented in the same cycle as the tick that ends the current word. That tick sends bit 0 of the new word, so there is no gap between the words.
- R8: While `in_ready` is 0, `in_valid` and `in_data` have no effect. A word offered then and withdrawn before `in_ready` rises is never sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_tick | input | 1 | One-cycle pulse that advances the line by one bit |
| in_valid | input | 1 | Word offered |
| in_data | input | WORD_W | Word to send, bit 0 goes out first |
| in_ready | output | 1 | Encoder can take a word this cycle |
| ds_data | output | 1 | Serial data line |
| ds_strobe | output | 1 | Strobe line, inverts when a bit repeats |

## Verification
The hardest situation to reach is a handshake in the same cycle as the tick that retires the current word's last bit. In that cycle the incoming word goes to the line directly, without waiting in the holding register. The bench reaches it by sweeping every byte value twice back to back. The first sweep ticks on alternate cycles, so words wait in the holding register. The second sweep ticks on every cycle, so every word boundary goes through the bypass path. A pseudo-random phase then mixes sparse ticks, dropped valids and idle gaps, so that words start after idle following both a 0 and a 1 last bit.

// File: rtl/ds_tx_pkg.sv
package ds_tx_pkg;

   // what the word scheduler asks the line coder to do at a clock edge
   typedef enum logic [1:0] {
      OP_HOLD = 2'd0,
      OP_BIT  = 2'd1,
      OP_REST = 2'd2
   } line_op_e;

   // line pair after coding bit b against the current pair {d, s}
   function automatic logic [1:0] ds_code(input logic d, input logic s, input logic b);
      logic [1:0] r;
      if (b == d) r = {d, ~s};
      else        r = {b, s};
      return r;
   endfunction

endpackage

// File: rtl/ds_word_sched.sv
module ds_word_sched
   import ds_tx_pkg::*;
#(
   parameter int WORD_W    = 8,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bit_tick,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_data,
   output logic              in_ready,
   output line_op_e          op,
   output logic              bit_val,
   output logic              active
);

   localparam int IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

   logic              active_q;
   logic              pend_q;
   logic [IDX_W-1:0]  idx_q;
   logic [WORD_W-1:0] word_q;
   logic [WORD_W-1:0] pword_q;

   logic              last_on_line;
   logic              fire;
   logic              src_avail;
   logic [WORD_W-1:0] src_word;
   logic [WORD_W-1:0] sel_word;
   logic [IDX_W-1:0]  sel_idx;
   logic              mid_word;

   assign last_on_line = active_q && (idx_q == LAST_IDX);
   assign mid_word     = active_q && (idx_q != LAST_IDX);
   assign in_ready     = !pend_q && (!active_q || last_on_line);
   assign fire         = in_valid && in_ready;
   assign src_avail    = pend_q || fire;
   assign src_word     = pend_q ? pword_q : in_data;
   assign active       = active_q;

   always_comb begin
      op       = OP_HOLD;
      sel_word = word_q;
      sel_idx  = idx_q + IDX_W'(1);
      if (bit_tick) begin
         if (mid_word) begin
            op = OP_BIT;
         end else if (src_avail) begin
            op       = OP_BIT;
            sel_word = src_word;
            sel_idx  = '0;
         end else begin
            op = OP_REST;
         end
      end
   end

   generate
      if (LSB_FIRST) begin : g_lsb
         assign bit_val = sel_word[sel_idx];
      end else begin : g_msb
         assign bit_val = sel_word[LAST_IDX - sel_idx];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         active_q <= 1'b0;
         pend_q   <= 1'b0;
         idx_q    <= '0;
         word_q   <= '0;
         pword_q  <= '0;
      end else if (bit_tick) begin
         if (mid_word) begin
            idx_q <= idx_q + IDX_W'(1);
         end else if (src_avail) begin
            word_q   <= src_word;
            idx_q    <= '0;
            active_q <= 1'b1;
            pend_q   <= 1'b0;
         end else begin
            active_q <= 1'b0;
         end
      end else if (fire) begin
         pend_q  <= 1'b1;
         pword_q <= in_data;
      end
   end

endmodule

// File: rtl/ds_line_coder.sv
module ds_line_coder
   import ds_tx_pkg::*;
#(
   parameter bit REST_LEVEL   = 1'b1,
   parameter bit STROBE_RESET = 1'b0
) (
   input  logic     clk,
   input  logic     rst,
   input  line_op_e op,
   input  logic     bit_val,
   output logic     ds_data,
   output logic     ds_strobe
);

   logic d_q;
   logic s_q;
   logic [1:0] coded;

   assign coded = ds_code(d_q, s_q, bit_val);

   always_ff @(posedge clk) begin
      if (rst) begin
         d_q <= REST_LEVEL;
         s_q <= STROBE_RESET;
      end else begin
         case (op)
            OP_BIT:  {d_q, s_q} <= coded;
            OP_REST: d_q <= REST_LEVEL;
            default: ;
         endcase
      end
   end

   assign ds_data   = d_q;
   assign ds_strobe = s_q;

endmodule

// File: rtl/ds_strobe_encoder.sv
module ds_strobe_encoder
   import ds_tx_pkg::*;
#(
   parameter int WORD_W    = 8,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bit_tick,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_data,
   output logic              in_ready,
   output logic              ds_data,
   output logic              ds_strobe
);

   generate
      if (WORD_W < 2) begin : g_bad_width
         $error("ds_strobe_encoder: WORD_W must be at least 2");
      end
   endgenerate

   line_op_e op_w;
   logic     bit_val_w;
   logic     active_w;
   logic     bit_emit_w;

   assign bit_emit_w = (op_w == OP_BIT);

   ds_word_sched #(
      .WORD_W    (WORD_W),
      .LSB_FIRST (LSB_FIRST)
   ) sched_i (
      .clk      (clk),
      .rst      (rst),
      .bit_tick (bit_tick),
      .in_valid (in_valid),
      .in_data  (in_data),
      .in_ready (in_ready),
      .op       (op_w),
      .bit_val  (bit_val_w),
      .active   (active_w)
   );

   ds_line_coder #(
      .REST_LEVEL   (1'b1),
      .STROBE_RESET (1'b0)
   ) coder_i (
      .clk       (clk),
      .rst       (rst),
      .op        (op_w),
      .bit_val   (bit_val_w),
      .ds_data   (ds_data),
      .ds_strobe (ds_strobe)
   );

endmodule

// File: rtl/ds_strobe_encoder_chk.sv
module ds_strobe_encoder_chk (
   input logic clk,
   input logic rst,
   input logic bit_tick,
   input logic in_valid,
   input logic in_ready,
   input logic ds_data,
   input logic ds_strobe,
   input logic bit_emit,
   input logic line_active
);

   logic past_ok = 1'b0;
   always_ff @(posedge clk) past_ok <= 1'b1;

   assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
      past_ok && $past(rst) |-> ds_data && !ds_strobe && in_ready);

   assert_one_line_change_R3: assert property (@(posedge clk) disable iff (rst)
      past_ok && !$past(rst) && $past(bit_emit) |->
         $countones({ds_data ^ $past(ds_data), ds_strobe ^ $past(ds_strobe)}) == 1);

   assert_hold_without_tick_R4: assert property (@(posedge clk) disable iff (rst)
      past_ok && !$past(rst) && !$past(bit_tick) |-> $stable(ds_data) && $stable(ds_strobe));

   assert_idle_high_R5: assert property (@(posedge clk) disable iff (rst)
      !line_active |-> ds_data);

   assert_idle_strobe_kept_R5: assert property (@(posedge clk) disable iff (rst)
      past_ok && !$past(rst) && $past(bit_tick) && !$past(bit_emit) |-> $stable(ds_strobe));

   assert_ready_drops_R6: assert property (@(posedge clk) disable iff (rst)
      past_ok && !$past(rst) && $past(in_valid && in_ready) |-> !in_ready);

endmodule

bind ds_strobe_encoder ds_strobe_encoder_chk chk_i (
   .clk         (clk),
   .rst         (rst),
   .bit_tick    (bit_tick),
   .in_valid    (in_valid),
   .in_ready    (in_ready),
   .ds_data     (ds_data),
   .ds_strobe   (ds_strobe),
   .bit_emit    (bit_emit_w),
   .line_active (active_w)
);

// File: tb/ds_strobe_encoder_tb_top.sv
module ds_strobe_encoder_tb_top;

   localparam int W = 8;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic         rst;
   logic         bit_tick;
   logic         in_valid;
   logic [W-1:0] in_data;
   logic         in_ready;
   logic         ds_data;
   logic         ds_strobe;

   ds_strobe_encoder #(.WORD_W(W), .LSB_FIRST(1'b1)) dut_i (
      .clk       (clk),
      .rst       (rst),
      .bit_tick  (bit_tick),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .in_ready  (in_ready),
      .ds_data   (ds_data),
      .ds_strobe (ds_strobe)
   );

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   // reference state, derived from the requirements
   logic         m_active = 1'b0;
   logic         m_pend   = 1'b0;
   int           m_idx    = 0;
   logic [W-1:0] m_word   = '0;
   logic [W-1:0] m_pword  = '0;
   logic         m_d      = 1'b1;
   logic         m_s      = 1'b0;
   int           bypass_cnt = 0;
   string        phase_tag  = "";
   logic [15:0]  lf = 16'hACE1;

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   task automatic lf_next();
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
   endtask

   // called at a negedge: drive inputs, check ready, advance model, check lines
   task automatic step(input logic tick, input logic v, input logic [W-1:0] dat,
                       output logic fired);
      logic exp_ready, pd, ps, emitted, bv, was_bypass, use_p;
      string td, ts;
      bit_tick = tick;
      in_valid = v;
      in_data  = dat;
      exp_ready = !m_pend && (!m_active || m_idx == W - 1);
      #1;
      chk((phase_tag != "") ? {phase_tag, " ready"} : "R6 ready", in_ready, exp_ready);
      fired = v && exp_ready;
      pd = m_d; ps = m_s; emitted = 1'b0; bv = 1'b0; was_bypass = 1'b0;
      if (tick) begin
         if (m_active && m_idx != W - 1) begin
            m_idx++;
            bv = m_word[m_idx];
            emitted = 1'b1;
         end else if (m_pend || fired) begin
            use_p = m_pend;
            if (!use_p && m_active) begin
               bypass_cnt++;
               was_bypass = 1'b1;
            end
            m_word   = use_p ? m_pword : dat;
            m_idx    = 0;
            m_active = 1'b1;
            m_pend   = 1'b0;
            bv       = m_word[0];
            emitted  = 1'b1;
         end else begin
            m_active = 1'b0;
            m_d      = 1'b1;
         end
         if (emitted) begin
            if (bv == m_d) m_s = ~m_s;
            else           m_d = bv;
         end
      end else if (fired) begin
         m_pend  = 1'b1;
         m_pword = dat;
      end
      @(posedge clk);
      @(negedge clk);
      if (phase_tag != "")  begin td = {phase_tag, " data"}; ts = {phase_tag, " strobe"}; end
      else if (was_bypass)  begin td = "R7 data";  ts = "R7 strobe"; end
      else if (!m_active)   begin td = "R5 data";  ts = "R5 strobe"; end
      else if (tick)        begin td = "R2 data";  ts = "R3 strobe"; end
      else                  begin td = "R4 data";  ts = "R4 strobe"; end
      chk(td, ds_data, m_d);
      chk(ts, ds_strobe, m_s);
      if (emitted)
         chk("R3 one line changed", ((ds_data ^ pd) ^ (ds_strobe ^ ps)) == 1'b1 &&
                                    !((ds_data ^ pd) && (ds_strobe ^ ps)), 1'b1);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin : main
      logic f;
      int b;
      int cyc;
      rst = 1'b1; bit_tick = 1'b0; in_valid = 1'b0; in_data = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      #1;
      chk("R1 data after reset", ds_data, 1'b1);
      chk("R1 strobe after reset", ds_strobe, 1'b0);
      chk("R1 ready after reset", in_ready, 1'b1);
      @(negedge clk);

      // sweep A: every byte, tick on alternate cycles (words wait in holding register)
      b = 0; cyc = 0;
      while (b < 256 && cyc < 20000) begin
         step((cyc % 2) == 1, 1'b1, W'(b), f);
         if (f) b++;
         cyc++;
      end
      for (int k = 0; k < 24; k++) step(k[0], 1'b0, '0, f);

      // sweep B: every byte reversed, tick each cycle (bypass at each boundary)
      bypass_cnt = 0;
      b = 0; cyc = 0;
      while (b < 256 && cyc < 20000) begin
         step(1'b1, 1'b1, W'(255 - b), f);
         if (f) b++;
         cyc++;
      end
      chk("R7 bypass path used", bypass_cnt > 200, 1'b1);
      for (int k = 0; k < 12; k++) step(1'b1, 1'b0, '0, f);

      // random mix: sparse ticks, dropped valids, idle gaps
      for (int k = 0; k < 4000; k++) begin
         lf_next();
         step(lf[0] & lf[3], lf[5] | lf[9], lf[15:8], f);
      end
      for (int k = 0; k < 12; k++) step(1'b1, 1'b0, '0, f);

      // R4: long stretch with no tick in the middle of a word
      step(1'b0, 1'b1, 8'h96, f);
      step(1'b1, 1'b0, '0, f);
      step(1'b1, 1'b0, '0, f);
      phase_tag = "R4";
      for (int k = 0; k < 20; k++) step(1'b0, 1'b0, '0, f);
      phase_tag = "";
      for (int k = 0; k < 12; k++) step(1'b1, 1'b0, '0, f);

      // R8: offer a second word while not ready, withdraw it before ready rises
      phase_tag = "R8";
      step(1'b0, 1'b1, 8'hA5, f);
      for (int k = 0; k < 7; k++) step(1'b1, 1'b1, 8'h3C, f);
      for (int k = 0; k < 6; k++) step(1'b1, 1'b0, 8'h3C, f);
      chk("R8 withdrawn word not sent, line idle high", ds_data, 1'b1);
      chk("R8 ready back after idle", in_ready, 1'b1);
      phase_tag = "";

      // R5: first bit after idle, both polarities of the last sent bit
      step(1'b1, 1'b1, 8'h7F, f);
      for (int k = 0; k < 10; k++) step(1'b1, 1'b0, '0, f);
      step(1'b1, 1'b1, 8'h80, f);
      for (int k = 0; k < 10; k++) step(1'b1, 1'b0, '0, f);
      chk("R5 idle data high", ds_data, 1'b1);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule